// File: doc/BRIEF.md
# Sixteen-Line GPIO Controller with Per-Line Interrupt Styles

This block gives a CPU control of sixteen general-purpose pins through a small 32-bit register bus. Software sets a value to drive on each pin, decides per pin whether the pad driver is on or off, and reads back the pad levels after they have passed a two-flop synchronizer. The bus has no handshake: a write takes effect on the clock edge at which the write enable is high, and read data follows the address combinationally.

Each line also carries a 3-bit detection style. The styles are level high, level low, rising edge, falling edge and any edge, and the remaining codes switch detection off. Detected events latch into a status register that software clears by writing ones. The lower thirteen lines drive dedicated active-high interrupt outputs that follow their status bits.

Top module: `gpio16_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the output data register reads 0x0000, the direction register (offset 0x04) reads 0xFFFF so every line is an input, both style registers and the status register read 0, pad_oe is 0 and irq_out is 0.
- R2: Offset 0x00 holds the output data, whose bits [15:0] drive pad_out. Offset 0x04 holds the direction: a 1 in bit n turns off the pad driver of line n (pad_oe[n]=0) and a 0 turns it on. Both registers read back what was written.
- R3: Offset 0x08 returns pad_in in bits [15:0] as it stood two clock edges earlier. Writes to offset 0x08 are ignored.
- R4: The style of line n is held in bits [3k+2:3k] of offset 0x10 for n<8 (k=n) and of offset 0x14 for n>=8 (k=n-8). Bits [31:24] of both registers read 0.
- R5: Style 0 (level high) sets the line's status bit on the third clock edge after the pad goes high. While the level persists, the bit is set again after it is cleared.
- R6: Style 1 (level low) sets the status bit while the synchronized pad is low. This includes the first edge after the style is written.
- R7: Style 2 (rising edge) sets the status bit on the third edge after a low-to-high pad change. The bit stays set after the pad falls, until it is cleared.
- R8: Style 3 (falling edge) sets the status bit only on a high-to-low change, three edges after that change.
- R9: Style 4 (any edge) sets the status bit on both rising and falling pad changes.
- R10: Style codes 5, 6 and 7 never set the status bit, whatever the pad does.
- R11: Writing offset 0x0C clears each status bit (bits [15:0]) whose data bit is 1. A 0 leaves the bit unchanged. If a detection occurs in the same cycle as the clear, the detection wins.
- R12: irq_out[n] equals status bit n for lines 0 to 12. Lines 13 to 15 latch status that can be read at offset 0x0C but drive no output.
- R13: Offsets other than 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14 read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr_en | input | 1 | Write strobe for the register bus |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | 16 | Pad levels, asynchronous |
| pad_out | output | 16 | Output data driven toward the pads |
| pad_oe | output | 16 | Pad driver enable, 1 = drive |
| irq_out | output | 13 | Per-line interrupt outputs for lines 0 to 12 |

## Verification
A pad change shows up at offset 0x08 after two edges, and in the status register and on irq_out after three. A register write shows up on the first edge. For a level-low style, status sets on the edge that follows the style write. The bench drives every input just after a rising edge and samples on the falling edge. For the three-edge path it checks that status is still 0 after two edges and set after the third, so a stage added or removed anywhere in the path shows up as a mismatch. Sticky behaviour is checked by reading status several cycles after the pad has returned, with no clear in between.

// File: rtl/gpio_ctrl_pkg.sv
// Package: shared constants for the GPIO controller.
// Assumes byte offsets on a word-aligned bus; style codes are 3 bits wide.
package gpio_ctrl_pkg;
    localparam int unsigned OFS_DOUT   = 'h00;
    localparam int unsigned OFS_DIR    = 'h04;
    localparam int unsigned OFS_DIN    = 'h08;
    localparam int unsigned OFS_STAT   = 'h0C;
    localparam int unsigned OFS_STY_LO = 'h10;
    localparam int unsigned OFS_STY_HI = 'h14;

    localparam logic [2:0] STY_LVL_HI = 3'd0;
    localparam logic [2:0] STY_LVL_LO = 3'd1;
    localparam logic [2:0] STY_RISE   = 3'd2;
    localparam logic [2:0] STY_FALL   = 3'd3;
    localparam logic [2:0] STY_ANY    = 3'd4;
endpackage

// File: rtl/gpio_sync.sv
// Module: gpio_sync
// Two-flop synchronizer for a vector of asynchronous pad inputs.
// Assumes each bit is independent (no multi-bit coherence is needed).
module gpio_sync #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/gpio_event_detect.sv
// Module: gpio_event_detect
// Per-line level/edge detection and sticky status with write-one clear.
// Assumes lvl is already synchronized; a detection beats a same-cycle clear.
module gpio_event_detect
    import gpio_ctrl_pkg::*;
#(
    parameter int unsigned N  = 16,
    parameter int unsigned SW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  lvl,
    input  logic [N*SW-1:0] style,
    input  logic [N-1:0]  clr,
    output logic [N-1:0]  status
);
    logic [N-1:0] prev;
    logic [N-1:0] hit;

    // Previous synchronized level, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= lvl;
    end

    for (genvar i = 0; i < N; i++) begin : g_line
        logic [SW-1:0] sty;
        logic          rise;
        logic          fall;
        assign sty  = style[i*SW +: SW];
        assign rise = lvl[i] & ~prev[i];
        assign fall = ~lvl[i] & prev[i];

        // Select this line's trigger condition from its style code.
        always_comb begin
            case (sty)
                SW'(STY_LVL_HI): hit[i] = lvl[i];
                SW'(STY_LVL_LO): hit[i] = ~lvl[i];
                SW'(STY_RISE):   hit[i] = rise;
                SW'(STY_FALL):   hit[i] = fall;
                SW'(STY_ANY):    hit[i] = rise | fall;
                default:         hit[i] = 1'b0;
            endcase
        end

        // Sticky status: clear by write-one, set on detection (set wins).
        always_ff @(posedge clk) begin
            if (!rst_n) status[i] <= 1'b0;
            else        status[i] <= (status[i] & ~clr[i]) | hit[i];
        end

        a_r5_level_high: assert property (@(posedge clk) disable iff (!rst_n)
            (sty == SW'(STY_LVL_HI) && lvl[i]) |=> status[i]);
        a_r6_level_low: assert property (@(posedge clk) disable iff (!rst_n)
            (sty == SW'(STY_LVL_LO) && !lvl[i]) |=> status[i]);
        a_r7_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (sty >= SW'(STY_RISE) && status[i] && !clr[i]) |=> status[i]);
        a_r10_disabled: assert property (@(posedge clk) disable iff (!rst_n)
            (sty > SW'(STY_ANY) && !status[i]) |=> !status[i]);
        a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (sty > SW'(STY_ANY) && clr[i]) |=> !status[i]);
    end
endmodule

// File: rtl/gpio_regfile.sv
// Module: gpio_regfile
// Bus-visible registers: output data, direction, two style words,
// the status clear strobe and the read multiplexer.
// Assumes N == 2*LPR so two style words cover every line.
module gpio_regfile
    import gpio_ctrl_pkg::*;
#(
    parameter int unsigned N      = 16,
    parameter int unsigned SW     = 3,
    parameter int unsigned LPR    = 8,
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [N-1:0]      din,
    input  logic [N-1:0]      status,
    output logic [N-1:0]      dout,
    output logic [N-1:0]      dir,
    output logic [N*SW-1:0]   style,
    output logic [N-1:0]      clr
);
    localparam int unsigned STY_BITS = LPR * SW;

    // Register writes; reset makes all lines inputs with style 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout  <= '0;
            dir   <= '1;
            style <= '0;
        end else if (wr_en) begin
            case (addr)
                ADDR_W'(OFS_DOUT):   dout <= wdata[N-1:0];
                ADDR_W'(OFS_DIR):    dir  <= wdata[N-1:0];
                ADDR_W'(OFS_STY_LO): style[0 +: STY_BITS]        <= wdata[STY_BITS-1:0];
                ADDR_W'(OFS_STY_HI): style[STY_BITS +: STY_BITS] <= wdata[STY_BITS-1:0];
                default: ;
            endcase
        end
    end

    // Write-one-to-clear strobe toward the status bits.
    always_comb begin
        clr = '0;
        if (wr_en && addr == ADDR_W'(OFS_STAT)) clr = wdata[N-1:0];
    end

    // Read multiplexer; unmapped offsets return zero.
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(OFS_DOUT):   rdata[N-1:0] = dout;
            ADDR_W'(OFS_DIR):    rdata[N-1:0] = dir;
            ADDR_W'(OFS_DIN):    rdata[N-1:0] = din;
            ADDR_W'(OFS_STAT):   rdata[N-1:0] = status;
            ADDR_W'(OFS_STY_LO): rdata[STY_BITS-1:0] = style[0 +: STY_BITS];
            ADDR_W'(OFS_STY_HI): rdata[STY_BITS-1:0] = style[STY_BITS +: STY_BITS];
            default: ;
        endcase
    end

    a_r2_dout_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_DOUT)) |=> dout == $past(wdata[N-1:0]));
    a_r13_no_side_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_DIN)) |=> ($stable(dout) && $stable(dir) && $stable(style)));
endmodule

// File: rtl/gpio16_ctrl.sv
// Module: gpio16_ctrl (top)
// Sixteen-line GPIO controller: register file, pad synchronizer,
// per-line interrupt detection and dedicated interrupt outputs.
// Assumes N_IRQ <= N; lines at and above N_IRQ have no output.
module gpio16_ctrl #(
    parameter int unsigned N      = 16,
    parameter int unsigned N_IRQ  = 13,
    parameter int unsigned SW     = 3,
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N-1:0]      pad_in,
    output logic [N-1:0]      pad_out,
    output logic [N-1:0]      pad_oe,
    output logic [N_IRQ-1:0]  irq_out
);
    localparam int unsigned LPR = N / 2;

    logic [N-1:0]    din;
    logic [N-1:0]    status;
    logic [N-1:0]    dout;
    logic [N-1:0]    dir;
    logic [N*SW-1:0] style;
    logic [N-1:0]    clr;

    gpio_sync #(.W(N)) i_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(din)
    );

    gpio_regfile #(.N(N), .SW(SW), .LPR(LPR), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .din(din), .status(status),
        .dout(dout), .dir(dir), .style(style), .clr(clr)
    );

    gpio_event_detect #(.N(N), .SW(SW)) i_detect (
        .clk(clk), .rst_n(rst_n), .lvl(din), .style(style),
        .clr(clr), .status(status)
    );

    // Pad drive: a direction bit of 1 means input, so the driver is off.
    assign pad_out = dout;
    assign pad_oe  = ~dir;
    // Dedicated interrupt outputs follow the low status bits.
    assign irq_out = status[N_IRQ-1:0];

    a_r1_reset_inputs: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0 && irq_out == '0));
    a_r12_irq_clear_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == ADDR_W'(gpio_ctrl_pkg::OFS_STAT) && bus_wdata[0]
         && style[SW-1:0] > 3'd4) |=> !irq_out[0]);
endmodule

// File: tb/test_gpio16_ctrl.sv
// Scoreboard bench: driver tasks push expected items; a monitor on the
// falling edge pops and compares them against the design's outputs.
module test_gpio16_ctrl;
    localparam int unsigned N = 16;

    typedef struct packed {
        int          kind;   // 0 rdata, 1 irq_out, 2 pad_oe, 3 pad_out
        logic [31:0] val;
        int          req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_out;
    logic [15:0] pad_oe;
    logic [12:0] irq_out;

    int   checks = 0;
    int   errors = 0;
    int   cycles = 0;
    exp_t sb[$];

    always #4 clk = ~clk;  // 125 MHz

    gpio16_ctrl i_gpio16_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq_out)
    );

    // Monitor: compare every queued expectation on the falling edge.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            exp_t e;
            logic [31:0] act;
            e = sb.pop_front();
            case (e.kind)
                0: act = bus_rdata;
                1: act = {19'd0, irq_out};
                2: act = {16'd0, pad_oe};
                default: act = {16'd0, pad_out};
            endcase
            checks++;
            if (act !== e.val) begin
                errors++;
                $display("FAIL R%0d kind %0d actual 0x%08h expected 0x%08h", e.req, e.kind, act, e.val);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr_en = 1'b0;
    endtask

    task automatic chk_port(int kind, logic [31:0] v, int req);
        exp_t e;
        e.kind = kind; e.val = v; e.req = req;
        sb.push_back(e);
    endtask

    task automatic chk_rd(logic [4:0] a, logic [31:0] v, int req);
        bus_addr = a;
        chk_port(0, v, req);
        step();
    endtask

    function automatic logic [31:0] sty_word(int k, logic [2:0] v);
        logic [31:0] w;
        w = 32'h00FF_FFFF;
        w &= ~(32'h7 << (3 * k));
        w |= {29'd0, v} << (3 * k);
        return w;
    endfunction

    initial begin
        step(3);
        rst_n = 1'b1;
        step();
        // R1: reset state
        chk_port(1, 32'h0, 1);
        chk_port(2, 32'h0, 1);
        chk_rd(5'h00, 32'h0, 1);
        chk_rd(5'h04, 32'h0000_FFFF, 1);
        chk_rd(5'h0C, 32'h0, 1);
        chk_rd(5'h10, 32'h0, 1);
        chk_rd(5'h14, 32'h0, 1);

        // R4: upper bits read zero; all fields 7 disables detection
        wr(5'h10, 32'hFFFF_FFFF);
        wr(5'h14, 32'hFFFF_FFFF);
        chk_rd(5'h10, 32'h00FF_FFFF, 4);
        chk_rd(5'h14, 32'h00FF_FFFF, 4);

        // R2: output data and direction
        wr(5'h00, 32'h0000_A5C3);
        wr(5'h04, 32'h0000_00FF);
        chk_port(2, 32'h0000_FF00, 2);
        chk_port(3, 32'h0000_A5C3, 2);
        chk_rd(5'h04, 32'h0000_00FF, 2);
        chk_rd(5'h00, 32'h0000_A5C3, 2);
        wr(5'h04, 32'h0000_FFFF);
        chk_port(2, 32'h0, 2);
        step();

        // R3: two-edge input path, read-only; R10: disabled styles never set
        pad_in = 16'h1234;
        step();
        chk_rd(5'h08, 32'h0, 3);          // after one edge: old value
        chk_rd(5'h08, 32'h0000_1234, 3);  // after two edges: new value
        wr(5'h08, 32'hFFFF_FFFF);
        chk_rd(5'h08, 32'h0000_1234, 3);
        pad_in = 16'hFFFF;
        step(3);
        pad_in = 16'h0000;
        step(3);
        chk_rd(5'h0C, 32'h0, 10);         // R10
        chk_port(1, 32'h0, 10);
        step();

        // R5 + R4 field position: line 9 level high (second word, k=1)
        wr(5'h14, sty_word(1, 3'd0));
        pad_in[9] = 1'b1;
        step(2);
        chk_rd(5'h0C, 32'h0, 5);          // not yet after two edges
        chk_port(1, 32'h0000_0200, 5);
        chk_rd(5'h0C, 32'h0000_0200, 5);  // third edge
        wr(5'h0C, 32'h0000_0200);         // R11: detection wins over clear
        chk_rd(5'h0C, 32'h0000_0200, 5);
        pad_in[9] = 1'b0;
        step(3);
        wr(5'h0C, 32'h0000_0200);
        chk_rd(5'h0C, 32'h0, 5);
        wr(5'h14, 32'hFFFF_FFFF);

        // R6: line 0 level low sets on the edge after the style write
        wr(5'h10, sty_word(0, 3'd1));
        step();
        chk_port(1, 32'h0000_0001, 6);
        chk_rd(5'h0C, 32'h0000_0001, 6);
        pad_in[0] = 1'b1;
        step(3);
        wr(5'h0C, 32'h0000_0001);
        chk_rd(5'h0C, 32'h0, 6);
        wr(5'h10, 32'hFFFF_FFFF);
        pad_in[0] = 1'b0;
        step(3);

        // R7: line 12 rising edge, sticky after the pad falls
        wr(5'h14, sty_word(4, 3'd2));
        pad_in[12] = 1'b1;
        step(2);
        chk_rd(5'h0C, 32'h0, 7);
        chk_port(1, 32'h0000_1000, 7);   // R12: line 12 output
        chk_rd(5'h0C, 32'h0000_1000, 7);
        pad_in[12] = 1'b0;
        step(4);
        chk_rd(5'h0C, 32'h0000_1000, 7);
        wr(5'h0C, 32'h0000_1000);
        step(2);
        chk_rd(5'h0C, 32'h0, 7);
        wr(5'h14, 32'hFFFF_FFFF);

        // R8: line 13 falling edge; R12: no output for line 13
        wr(5'h14, sty_word(5, 3'd3));
        pad_in[13] = 1'b1;
        step(4);
        chk_rd(5'h0C, 32'h0, 8);
        pad_in[13] = 1'b0;
        step(2);
        chk_rd(5'h0C, 32'h0, 8);
        chk_port(1, 32'h0, 12);
        chk_rd(5'h0C, 32'h0000_2000, 8);
        wr(5'h0C, 32'h0000_2000);
        chk_rd(5'h0C, 32'h0, 8);
        wr(5'h14, 32'hFFFF_FFFF);

        // R9: line 3 any edge, both directions
        wr(5'h10, sty_word(3, 3'd4));
        pad_in[3] = 1'b1;
        step(3);
        chk_port(1, 32'h0000_0008, 9);
        chk_rd(5'h0C, 32'h0000_0008, 9);
        // R11: zero bits leave status alone
        wr(5'h0C, 32'h0000_0000);
        chk_rd(5'h0C, 32'h0000_0008, 11);
        wr(5'h0C, 32'h0000_FFF7);
        chk_rd(5'h0C, 32'h0000_0008, 11);
        wr(5'h0C, 32'h0000_0008);
        chk_rd(5'h0C, 32'h0, 11);
        pad_in[3] = 1'b0;
        step(3);
        chk_rd(5'h0C, 32'h0000_0008, 9);
        wr(5'h0C, 32'h0000_0008);
        wr(5'h10, 32'hFFFF_FFFF);

        // R13: unmapped offsets read zero, writes have no effect
        wr(5'h18, 32'hFFFF_FFFF);
        wr(5'h1C, 32'hFFFF_FFFF);
        chk_rd(5'h18, 32'h0, 13);
        chk_rd(5'h1C, 32'h0, 13);
        chk_rd(5'h02, 32'h0, 13);
        chk_rd(5'h00, 32'h0000_A5C3, 13);
        chk_rd(5'h04, 32'h0000_FFFF, 13);
        chk_rd(5'h10, 32'h00FF_FFFF, 13);

        step(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule